// File: doc/BRIEF.md
# Thumbwheel Decade Store Loader

This block fills three six-decade BCD registers from a single shared 4-bit BCD bus. The registers hold the reload value, the early-warning value and the terminal value that feed an up/down decade counter. A bank of thumbwheel switches drives the bus. The switches are strobed by the same one-hot digit strobes that scan the display, so at any moment the bus carries the setting of exactly one decade.

Registers are not written by address. A two-bit target code selects which register, if any, takes the data. The digit strobe that is active identifies the decade. The write happens once the strobe's window has closed, using the bus value and target code present in the last clock cycle of that window. By then the switch contacts have had the whole window to settle. The scan steps from the most significant digit to the least significant, but any order works. Values above 9 are stored exactly as they appear on the bus.

Top module: `thumbwheel_store_loader`

## Requirements
- R1: While `rst_n` is low, all three register outputs read zero.
- R2: Target code `store_sel` = 2'b10 (bit 1 high, bit 0 low) writes only the early-warning register `presig_val`.
- R3: Target code `store_sel` = 2'b01 writes only the terminal register `main_val`.
- R4: Target code `store_sel` = 2'b11 writes only the reload register `preset_val`.
- R5: Target code `store_sel` = 2'b00 leaves all three registers unchanged when a strobe window closes.
- R6: Strobe bit k of `digit_sel` addresses decade k, which is bits [4k+3:4k] of each register. Bit 5 is the most significant decade and bit 0 the least.
- R7: The written decade takes the `bcd_in` and `store_sel` values from the last cycle in which its strobe was high. It updates on the first clock edge at which that strobe is seen low. Earlier values inside the window have no effect.
- R8: Bus values 10 to 15 are stored unchanged, with no BCD correction.
- R9: A write changes only the addressed decade of the selected register. The other decades and the other registers keep their values.
- R10: While no strobe window closes, changes on `bcd_in` and `store_sel` leave all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_sel | input | 6 | One-hot digit strobe; bit 5 is the most significant decade |
| bcd_in | input | 4 | BCD value of the strobed thumbwheel |
| store_sel | input | 2 | Target code: 00 none, 10 early-warning, 01 terminal, 11 reload |
| preset_val | output | 24 | Reload register, six BCD decades |
| presig_val | output | 24 | Early-warning register, six BCD decades |
| main_val | output | 24 | Terminal register, six BCD decades |

## Verification
A wrong captured strobe, bus or target value shows up on the register outputs on the edge just after the window closes. It appears as a wrong decade, the wrong register, or a digit taken from too early in the window. A stuck or dropped write enable shows as a decade that fails to change, or one that changes while no window closes or under code 00. Each of these is visible one cycle after the strobe falls. Corruption of a neighbouring decade shows at the same edge, because every check compares all 24 bits of all three registers.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'b00,
    SEL_MAIN   = 2'b01,
    SEL_PRESIG = 2'b10,
    SEL_PRESET = 2'b11
  } store_code_e;

  localparam int NUM_STORES   = 3;
  localparam int IDX_PRESET   = 0;
  localparam int IDX_PRESIG   = 1;
  localparam int IDX_MAIN     = 2;
endpackage

// File: rtl/tsl_reset_sync.sv
module tsl_reset_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;
endmodule

// File: rtl/tsl_strobe_tracker.sv
module tsl_strobe_tracker
  import tsl_pkg::*;
#(
  parameter int NUM_DIGITS = 6,
  parameter int DIGIT_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_DIGITS-1:0] digit_sel,
  input  logic [DIGIT_W-1:0]    bcd_in,
  input  logic [1:0]            store_sel,
  output logic [NUM_DIGITS-1:0] commit_mask,
  output logic [DIGIT_W-1:0]    commit_data,
  output store_code_e           commit_code
);
  logic [NUM_DIGITS-1:0] strobe_q;
  logic [DIGIT_W-1:0]    data_q, data_d;
  store_code_e           code_q, code_d;
  logic                  window_open;

  // Bus value and code follow the input only while some window is open,
  // so after the strobe falls they still hold the window's last cycle.
  always_comb begin
    window_open = |digit_sel;
    data_d      = data_q;
    code_d      = code_q;
    if (window_open) begin
      data_d = bcd_in;
      code_d = store_code_e'(store_sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= '0;
      data_q   <= '0;
      code_q   <= SEL_NONE;
    end else begin
      strobe_q <= digit_sel;
      data_q   <= data_d;
      code_q   <= code_d;
    end
  end

  assign commit_mask = strobe_q & ~digit_sel;
  assign commit_data = data_q;
  assign commit_code = code_q;
endmodule

// File: rtl/tsl_target_decode.sv
module tsl_target_decode
  import tsl_pkg::*;
#(
  parameter int NUM_DIGITS = 6
) (
  input  logic [NUM_DIGITS-1:0] commit_mask,
  input  store_code_e           commit_code,
  output logic [NUM_STORES-1:0] store_we
);
  logic any_commit;

  always_comb begin
    any_commit = |commit_mask;
    store_we   = '0;
    case (commit_code)
      SEL_PRESET: store_we[IDX_PRESET] = any_commit;
      SEL_PRESIG: store_we[IDX_PRESIG] = any_commit;
      SEL_MAIN:   store_we[IDX_MAIN]   = any_commit;
      default:    store_we             = '0;
    endcase
  end
endmodule

// File: rtl/tsl_decade_store.sv
module tsl_decade_store #(
  parameter int NUM_DIGITS = 6,
  parameter int DIGIT_W    = 4,
  localparam int REG_W     = NUM_DIGITS * DIGIT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [NUM_DIGITS-1:0] commit_mask,
  input  logic [DIGIT_W-1:0]    commit_data,
  output logic [REG_W-1:0]      value
);
  for (genvar gd = 0; gd < NUM_DIGITS; gd++) begin : g_decade
    logic [DIGIT_W-1:0] dec_q, dec_d;
    logic               dec_en;

    always_comb begin
      dec_en = we & commit_mask[gd];
      dec_d  = dec_en ? commit_data : dec_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dec_q <= '0;
      end else if (dec_en) begin
        dec_q <= dec_d;
      end
    end

    assign value[gd*DIGIT_W +: DIGIT_W] = dec_q;
  end
endmodule

// File: rtl/thumbwheel_store_loader.sv
module thumbwheel_store_loader
  import tsl_pkg::*;
#(
  parameter int NUM_DIGITS = 6,
  parameter int DIGIT_W    = 4,
  localparam int REG_W     = NUM_DIGITS * DIGIT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_DIGITS-1:0] digit_sel,
  input  logic [DIGIT_W-1:0]    bcd_in,
  input  logic [1:0]            store_sel,
  output logic [REG_W-1:0]      preset_val,
  output logic [REG_W-1:0]      presig_val,
  output logic [REG_W-1:0]      main_val
);
  logic                  rst_sync_n;
  logic [NUM_DIGITS-1:0] commit_mask;
  logic [DIGIT_W-1:0]    commit_data;
  store_code_e           commit_code;
  logic [NUM_STORES-1:0] store_we;
  logic [REG_W-1:0]      store_val [NUM_STORES];

  tsl_reset_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  tsl_strobe_tracker #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .digit_sel   (digit_sel),
    .bcd_in      (bcd_in),
    .store_sel   (store_sel),
    .commit_mask (commit_mask),
    .commit_data (commit_data),
    .commit_code (commit_code)
  );

  tsl_target_decode #(.NUM_DIGITS(NUM_DIGITS)) u_dec (
    .commit_mask (commit_mask),
    .commit_code (commit_code),
    .store_we    (store_we)
  );

  for (genvar gs = 0; gs < NUM_STORES; gs++) begin : g_store
    tsl_decade_store #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_store (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .we          (store_we[gs]),
      .commit_mask (commit_mask),
      .commit_data (commit_data),
      .value       (store_val[gs])
    );
  end

  assign preset_val = store_val[IDX_PRESET];
  assign presig_val = store_val[IDX_PRESIG];
  assign main_val   = store_val[IDX_MAIN];
endmodule

// File: rtl/tsl_checker.sv
module tsl_checker #(
  parameter int NUM_DIGITS = 6,
  parameter int DIGIT_W    = 4,
  localparam int REG_W     = NUM_DIGITS * DIGIT_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_DIGITS-1:0] digit_sel,
  input logic [DIGIT_W-1:0]    bcd_in,
  input logic [1:0]            store_sel,
  input logic [REG_W-1:0]      preset_val,
  input logic [REG_W-1:0]      presig_val,
  input logic [REG_W-1:0]      main_val
);
  logic [NUM_DIGITS-1:0] prev_sel;
  logic [DIGIT_W-1:0]    prev_data;
  logic [1:0]            prev_code;
  logic [NUM_DIGITS-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel  <= '0;
      prev_data <= '0;
      prev_code <= 2'b00;
    end else begin
      prev_sel <= digit_sel;
      if (|digit_sel) begin
        prev_data <= bcd_in;
        prev_code <= store_sel;
      end
    end
  end

  assign fall = prev_sel & ~digit_sel;

  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall == '0) |=> ($stable(preset_val) && $stable(presig_val) && $stable(main_val)));

  // R5
  no_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall != '0) && (prev_code == 2'b00)) |=>
      ($stable(preset_val) && $stable(presig_val) && $stable(main_val)));

  // R2
  presig_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall != '0) && (prev_code == 2'b10)) |=> ($stable(preset_val) && $stable(main_val)));

  // R3
  main_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall != '0) && (prev_code == 2'b01)) |=> ($stable(preset_val) && $stable(presig_val)));

  // R4
  preset_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall != '0) && (prev_code == 2'b11)) |=> ($stable(presig_val) && $stable(main_val)));

  for (genvar gk = 0; gk < NUM_DIGITS; gk++) begin : g_dec_chk
    // R6
    preset_decade_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall[gk] && (prev_code == 2'b11)) |=>
        (preset_val[gk*DIGIT_W +: DIGIT_W] == $past(prev_data)));
    // R6
    presig_decade_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall[gk] && (prev_code == 2'b10)) |=>
        (presig_val[gk*DIGIT_W +: DIGIT_W] == $past(prev_data)));
    // R6
    main_decade_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall[gk] && (prev_code == 2'b01)) |=>
        (main_val[gk*DIGIT_W +: DIGIT_W] == $past(prev_data)));
  end
endmodule

bind thumbwheel_store_loader tsl_checker #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .digit_sel  (digit_sel),
  .bcd_in     (bcd_in),
  .store_sel  (store_sel),
  .preset_val (preset_val),
  .presig_val (presig_val),
  .main_val   (main_val)
);

// File: tb/thumbwheel_store_loader_bench.sv
module thumbwheel_store_loader_bench;
  localparam int ND = 6;
  localparam int DW = 4;
  localparam int RW = ND * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [ND-1:0] digit_sel = '0;
  logic [DW-1:0] bcd_in = '0;
  logic [1:0]    store_sel = 2'b00;
  logic [RW-1:0] preset_val, presig_val, main_val;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // index 0 reload (code 11), 1 early-warning (code 10), 2 terminal (code 01)
  logic [RW-1:0] exp_val [3];

  // {digit, data, code}
  localparam logic [8:0] VEC [0:11] = '{
    {3'd5, 4'd1,  2'b10}, {3'd4, 4'd2,  2'b01}, {3'd3, 4'd3,  2'b11},
    {3'd0, 4'd9,  2'b10}, {3'd1, 4'd4,  2'b00}, {3'd5, 4'd8,  2'b11},
    {3'd2, 4'hA,  2'b01}, {3'd0, 4'hF,  2'b11}, {3'd3, 4'd6,  2'b10},
    {3'd4, 4'd0,  2'b11}, {3'd1, 4'd5,  2'b01}, {3'd2, 4'd7,  2'b00}
  };

  thumbwheel_store_loader u_thumbwheel_store_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .digit_sel  (digit_sel),
    .bcd_in     (bcd_in),
    .store_sel  (store_sel),
    .preset_val (preset_val),
    .presig_val (presig_val),
    .main_val   (main_val)
  );

  always #10ns clk = ~clk;

  function automatic int code_idx(logic [1:0] c);
    case (c)
      2'b11:   return 0;
      2'b10:   return 1;
      2'b01:   return 2;
      default: return -1;
    endcase
  endfunction

  function automatic void model_write(int k, logic [DW-1:0] d, logic [1:0] c);
    int s = code_idx(c);
    if (s >= 0) exp_val[s][k*DW +: DW] = d;
  endfunction

  task automatic check_all(string tag);
    logic [RW-1:0] act [3];
    act[0] = preset_val;
    act[1] = presig_val;
    act[2] = main_val;
    for (int s = 0; s < 3; s++) begin
      checks++;
      if (act[s] !== exp_val[s]) begin
        errors++;
        $display("FAIL %s store%0d: actual %h expected %h", tag, s, act[s], exp_val[s]);
      end
    end
  endtask

  task automatic hold_digit(int k, logic [DW-1:0] d, logic [1:0] c, int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      digit_sel = ND'(1) << k;
      bcd_in    = d;
      store_sel = c;
    end
  endtask

  task automatic close_and_check(string tag);
    @(negedge clk);
    digit_sel = '0;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 3; s++) exp_val[s] = '0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R1 after release");

    // Table walk: R2 R3 R4 R5 R6 R8 R9
    for (int v = 0; v < 12; v++) begin
      int            k = int'(VEC[v][8:6]);
      logic [DW-1:0] d = VEC[v][5:2];
      logic [1:0]    c = VEC[v][1:0];
      hold_digit(k, d, c, 2);
      model_write(k, d, c);
      close_and_check($sformatf("R2 R3 R4 R5 R6 R8 R9 vector %0d", v));
    end

    // R7: data and code change inside the window; last cycle wins
    hold_digit(2, 4'd3, 2'b10, 3);
    hold_digit(2, 4'd7, 2'b01, 1);
    model_write(2, 4'd7, 2'b01);
    close_and_check("R7 last cycle of window");

    // R10: bus and code toggle with no strobe
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      bcd_in    = DW'(i + 3);
      store_sel = 2'(i);
    end
    @(negedge clk);
    check_all("R10 idle bus activity");

    // R6 R9: back-to-back scan, most significant first, into reload
    for (int k = ND - 1; k >= 0; k--) begin
      hold_digit(k, DW'(k + 1), 2'b11, 2);
      model_write(k, DW'(k + 1), 2'b11);
    end
    close_and_check("R6 R9 full scan reload");

    // R8: full scan of 15s into terminal register
    for (int k = ND - 1; k >= 0; k--) begin
      hold_digit(k, 4'hF, 2'b01, 1);
      model_write(k, 4'hF, 2'b01);
    end
    close_and_check("R8 full scan of 15");

    // R5: a whole scan with code 00 changes nothing
    for (int k = ND - 1; k >= 0; k--) hold_digit(k, 4'd9, 2'b00, 2);
    close_and_check("R5 scan with no target");

    // R1: reset in the middle of a window
    hold_digit(3, 4'd5, 2'b10, 1);
    @(negedge clk);
    rst_n = 1'b0;
    for (int s = 0; s < 3; s++) exp_val[s] = '0;
    @(negedge clk);
    check_all("R1 mid-run reset");
    digit_sel = '0;
    @(negedge clk);
    check_all("R1 held in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    hold_digit(0, 4'd4, 2'b10, 2);
    model_write(0, 4'd4, 2'b10);
    close_and_check("R2 write after reset");

    finish_run();
  end
endmodule